// File: doc/BRIEF.md
# Dual-Die Shared-Bus Mode Decoder

This block sits between a host bus and a package in which a flash die and a pseudo-SRAM die share one 16-lane data bus, one output enable and one write enable. Each clock it samples the host's control pins and registers, for each die, the operating mode. It also registers which data lanes the package may drive back toward the host, and, when the flash runs as a byte-wide device, the extra lowest address bit that the top data lane carries in that mode.

The flash die has a single active-low select. The pseudo-SRAM die has two selects: an active-low one, and an active-high one whose low level puts the die into deep power down. The one combination of selects that would put both dies on the bus at once is treated as a fault. The decoder then keeps every lane quiet and latches an error flag. The flag stays set until the host pulses a clear input.

All control pins are plain level signals. No data passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `dual_die_mode_dec`

## Requirements
- R1: While `rst_n` is low, both mode outputs read standby (code 0), `lane_oe` is 0, `byte_addr_vld` and `byte_addr` are 0, and `contention_err` is 0.
- R2: Every output reflects the inputs sampled at one rising clock edge and changes only at that edge. There is exactly one register stage.
- R3: Mode codes are standby=0, output disable=1, read=2, write=3 and deep power down=4. The access type is decided as follows:
  - output enable low with write enable high gives read;
  - write enable low with output enable high gives write;
  - any other pairing gives output disable.
- R4: While `flash_sel_n` is high, `flash_mode` is standby, whatever the other inputs are.
- R5: While `ps_sel_hi` is low, `ps_mode` is deep power down, whatever `ps_sel_n` is. While `ps_sel_hi` is high and `ps_sel_n` is high, `ps_mode` is standby.
- R6: Forbidden state: `flash_sel_n` low, `ps_sel_n` low and `ps_sel_hi` high, all at once. In this state both modes read output disable, `lane_oe` is 0 and `contention_err` is set.
- R7: `contention_err` stays set until a cycle samples `err_clr` high while no forbidden state is sampled. If both are sampled in the same cycle, the flag is set.
- R8: A flash read with `wide_mode` high drives all 16 lanes (`lane_oe`=0xFFFF).
- R9: A flash read with `wide_mode` low drives only lanes 0 to 7 (`lane_oe`=0x00FF), whatever the pseudo-SRAM byte enables are.
- R10: During a flash read or write with `wide_mode` low, `byte_addr_vld` is 1 and `byte_addr` equals `lane15_in` (0 selects the low byte, 1 the high byte). In every other case both are 0.
- R11: In a pseudo-SRAM read, lanes 0 to 7 are driven when `ps_lo_n` is low, and lanes 8 to 15 when `ps_hi_n` is low.
- R12: Lanes are driven only while one die is in read mode, and the two dies are never in read mode together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_sel_n | input | 1 | Flash select, active low |
| ps_sel_n | input | 1 | Pseudo-SRAM first select, active low |
| ps_sel_hi | input | 1 | Pseudo-SRAM second select, active high; low means deep power down |
| rd_en_n | input | 1 | Shared output enable, active low |
| wr_en_n | input | 1 | Shared write enable, active low |
| wide_mode | input | 1 | Flash bus width: 1 = 16-bit, 0 = 8-bit |
| ps_hi_n | input | 1 | Pseudo-SRAM upper byte enable, active low |
| ps_lo_n | input | 1 | Pseudo-SRAM lower byte enable, active low |
| lane15_in | input | 1 | Level on data lane 15, used as an address bit in 8-bit flash mode |
| err_clr | input | 1 | Clears the contention flag |
| flash_mode | output | 3 | Flash die mode code |
| ps_mode | output | 3 | Pseudo-SRAM die mode code |
| lane_oe | output | 16 | Per-lane enable for the package to drive the bus |
| byte_addr_vld | output | 1 | Byte address bit is in use |
| byte_addr | output | 1 | Byte select within the flash word |
| contention_err | output | 1 | Sticky flag for the forbidden select state |

## Verification
Some properties are checked by the assertions on every cycle:
- lanes are only driven beside a read;
- two readers never coexist;
- the error flag is sticky;
- a forbidden sample silences the lanes;
- a deselected flash or a powered-down pseudo-SRAM yields the expected mode;
- 8-bit flash operation never enables the upper lanes.

Other behaviour can only be shown by the bench's scenarios, because it depends on chosen stimulus:
- the exact mode code for every pairing of the two enables;
- each byte-enable pattern;
- both levels of the byte address bit;
- the set-beats-clear case;
- the one-cycle timing of each output.

// File: rtl/ddm_pkg.sv
package ddm_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_OUT_DIS = 3'd1,
    MODE_READ    = 3'd2,
    MODE_WRITE   = 3'd3,
    MODE_DEEP_PD = 3'd4
  } die_mode_e;

  function automatic die_mode_e access_kind(input logic oe_n, input logic we_n);
    if (!oe_n && we_n)      return MODE_READ;
    else if (oe_n && !we_n) return MODE_WRITE;
    else                    return MODE_OUT_DIS;
  endfunction
endpackage

// File: rtl/ddm_flash_dec.sv
module ddm_flash_dec
  import ddm_pkg::*;
(
  input  logic      sel_n,
  input  logic      forbidden,
  input  logic      oe_n,
  input  logic      we_n,
  output die_mode_e mode
);
  always_comb begin
    if (forbidden)  mode = MODE_OUT_DIS;
    else if (sel_n) mode = MODE_STANDBY;
    else            mode = access_kind(oe_n, we_n);
  end
endmodule

// File: rtl/ddm_psram_dec.sv
module ddm_psram_dec
  import ddm_pkg::*;
(
  input  logic      sel_n,
  input  logic      sel_hi,
  input  logic      forbidden,
  input  logic      oe_n,
  input  logic      we_n,
  output die_mode_e mode
);
  always_comb begin
    if (forbidden)    mode = MODE_OUT_DIS;
    else if (!sel_hi) mode = MODE_DEEP_PD;
    else if (sel_n)   mode = MODE_STANDBY;
    else              mode = access_kind(oe_n, we_n);
  end
endmodule

// File: rtl/ddm_lane_ctrl.sv
module ddm_lane_ctrl
  import ddm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  die_mode_e                     f_mode,
  input  die_mode_e                     p_mode,
  input  logic                          wide,
  input  logic [DATA_W/BYTE_W-1:0]      be_n,
  input  logic                          top_lane,
  output logic [DATA_W-1:0]             oe,
  output logic                          addr_vld,
  output logic                          addr_bit
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  logic f_rd, p_rd, f_acc;
  assign f_rd  = (f_mode == MODE_READ);
  assign p_rd  = (p_mode == MODE_READ);
  assign f_acc = f_rd || (f_mode == MODE_WRITE);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic grp_on;
    // group 0 serves the narrow flash bus; upper groups only in wide mode
    if (g == 0) begin : g_low
      assign grp_on = f_rd || (p_rd && !be_n[g]);
    end else begin : g_up
      assign grp_on = (f_rd && wide) || (p_rd && !be_n[g]);
    end
    for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
      assign oe[g*BYTE_W + b] = grp_on;
    end
  end

  assign addr_vld = f_acc && !wide;
  assign addr_bit = addr_vld && top_lane;
endmodule

// File: rtl/dual_die_mode_dec.sv
module dual_die_mode_dec
  import ddm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_sel_n,
  input  logic              ps_sel_n,
  input  logic              ps_sel_hi,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic              wide_mode,
  input  logic              ps_hi_n,
  input  logic              ps_lo_n,
  input  logic              lane15_in,
  input  logic              err_clr,
  output logic [2:0]        flash_mode,
  output logic [2:0]        ps_mode,
  output logic [DATA_W-1:0] lane_oe,
  output logic              byte_addr_vld,
  output logic              byte_addr,
  output logic              contention_err
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  logic                 forbidden;
  die_mode_e            f_mode_d, p_mode_d;
  logic [DATA_W-1:0]    oe_d;
  logic                 vld_d, addr_d;
  logic [NUM_BYTES-1:0] be_n;

  assign forbidden = !flash_sel_n && !ps_sel_n && ps_sel_hi;
  assign be_n = {{(NUM_BYTES-1){ps_hi_n}}, ps_lo_n};

  ddm_flash_dec u_flash (
    .sel_n(flash_sel_n), .forbidden(forbidden),
    .oe_n(rd_en_n), .we_n(wr_en_n), .mode(f_mode_d)
  );

  ddm_psram_dec u_psram (
    .sel_n(ps_sel_n), .sel_hi(ps_sel_hi), .forbidden(forbidden),
    .oe_n(rd_en_n), .we_n(wr_en_n), .mode(p_mode_d)
  );

  ddm_lane_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lanes (
    .f_mode(f_mode_d), .p_mode(p_mode_d), .wide(wide_mode), .be_n(be_n),
    .top_lane(lane15_in), .oe(oe_d), .addr_vld(vld_d), .addr_bit(addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_mode     <= MODE_STANDBY;
      ps_mode        <= MODE_STANDBY;
      lane_oe        <= '0;
      byte_addr_vld  <= 1'b0;
      byte_addr      <= 1'b0;
      contention_err <= 1'b0;
    end else begin
      flash_mode    <= f_mode_d;
      ps_mode       <= p_mode_d;
      lane_oe       <= oe_d;
      byte_addr_vld <= vld_d;
      byte_addr     <= addr_d;
      if (forbidden)    contention_err <= 1'b1;
      else if (err_clr) contention_err <= 1'b0;
    end
  end

  p_lanes_need_reader_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe != '0) |-> (flash_mode == MODE_READ || ps_mode == MODE_READ));

  p_single_reader_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_mode == MODE_READ && ps_mode == MODE_READ));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (contention_err && !err_clr) |=> contention_err);

  p_forbidden_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_sel_n && !ps_sel_n && ps_sel_hi) |=> (contention_err && lane_oe == '0));

  p_flash_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sel_n |=> (flash_mode == MODE_STANDBY));

  p_deep_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_sel_hi |=> (ps_mode == MODE_DEEP_PD));

  p_narrow_upper_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_addr_vld |-> (lane_oe[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/dual_die_mode_dec_tb.sv
`timescale 1ns/1ps
module dual_die_mode_dec_tb_top;
  localparam int PERIOD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_n = 1'b1, s1_n = 1'b1, s2 = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic wide = 1'b1, hi_n = 1'b1, lo_n = 1'b1, l15 = 1'b0, clr = 1'b0;
  logic [2:0]  fm, pm;
  logic [15:0] loe;
  logic        bav, ba, err;

  typedef struct packed {
    logic [2:0]  fm;
    logic [2:0]  pm;
    logic [15:0] oe;
    logic        bav;
    logic        ba;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_bad = 0;
  logic  err_model = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_die_mode_dec dut_i (
    .clk(clk), .rst_n(rst_n), .flash_sel_n(f_n), .ps_sel_n(s1_n), .ps_sel_hi(s2),
    .rd_en_n(oe_n), .wr_en_n(we_n), .wide_mode(wide), .ps_hi_n(hi_n), .ps_lo_n(lo_n),
    .lane15_in(l15), .err_clr(clr), .flash_mode(fm), .ps_mode(pm), .lane_oe(loe),
    .byte_addr_vld(bav), .byte_addr(ba), .contention_err(err)
  );

  function automatic logic [2:0] acc(input logic o, input logic w);
    if (!o && w) return 3'd2;
    if (o && !w) return 3'd3;
    return 3'd1;
  endfunction

  task automatic drive(input logic a_f, a_s1, a_s2, a_oe, a_we, a_wide,
                       a_hi, a_lo, a_l15, a_clr, input string tag);
    exp_t e;
    logic forb;
    @(negedge clk);
    f_n = a_f; s1_n = a_s1; s2 = a_s2; oe_n = a_oe; we_n = a_we;
    wide = a_wide; hi_n = a_hi; lo_n = a_lo; l15 = a_l15; clr = a_clr;
    forb = !a_f && !a_s1 && a_s2;
    if (forb)      e.fm = 3'd1;
    else if (a_f)  e.fm = 3'd0;
    else           e.fm = acc(a_oe, a_we);
    if (forb)      e.pm = 3'd1;
    else if (!a_s2) e.pm = 3'd4;
    else if (a_s1) e.pm = 3'd0;
    else           e.pm = acc(a_oe, a_we);
    if (e.fm == 3'd2)      e.oe = a_wide ? 16'hFFFF : 16'h00FF;
    else if (e.pm == 3'd2) e.oe = {a_hi ? 8'h00 : 8'hFF, a_lo ? 8'h00 : 8'hFF};
    else                   e.oe = 16'h0000;
    e.bav = (e.fm == 3'd2 || e.fm == 3'd3) && !a_wide;
    e.ba  = e.bav && a_l15;
    if (forb)       err_model = 1'b1;
    else if (a_clr) err_model = 1'b0;
    e.err = err_model;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares one item per clock, half a phase after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{fm, pm, loe, bav, ba, err};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual fm=%0d pm=%0d oe=%h bav=%b ba=%b err=%b expected fm=%0d pm=%0d oe=%h bav=%b ba=%b err=%b",
                   t, a.fm, a.pm, a.oe, a.bav, a.ba, a.err,
                   e.fm, e.pm, e.oe, e.bav, e.ba, e.err);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    n_chk++;
    if ({fm, pm, loe, bav, ba, err} !== 25'd0) begin
      n_bad++;
      $display("FAIL R1: actual %h expected 0", {fm, pm, loe, bav, ba, err});
    end
    @(negedge clk); rst_n = 1'b1;
    // args: f_n s1_n s2 oe_n we_n wide hi_n lo_n l15 clr
    drive(1,1,1, 0,1, 1, 0,0, 1, 0, "R4 flash deselected, psram standby");
    drive(1,0,1, 0,1, 1, 0,0, 0, 0, "R4 R11 psram read both bytes");
    drive(1,0,1, 0,1, 1, 1,0, 0, 0, "R11 psram read low byte");
    drive(1,0,1, 0,1, 1, 0,1, 0, 0, "R11 psram read high byte");
    drive(1,0,1, 0,1, 1, 1,1, 0, 0, "R11 R12 psram read no bytes");
    drive(1,0,1, 1,0, 1, 0,0, 0, 0, "R3 psram write");
    drive(1,0,1, 1,1, 1, 0,0, 0, 0, "R3 psram output disable");
    drive(1,0,1, 0,0, 1, 0,0, 0, 0, "R3 both enables low");
    drive(1,0,0, 0,1, 1, 0,0, 0, 0, "R5 deep pd with sel low");
    drive(1,1,0, 0,1, 1, 0,0, 0, 0, "R5 deep pd with sel high");
    drive(0,1,1, 0,1, 1, 0,0, 0, 0, "R8 flash wide read");
    drive(0,1,0, 0,1, 0, 0,0, 0, 0, "R9 R10 flash narrow read low byte");
    drive(0,1,0, 0,1, 0, 0,0, 1, 0, "R9 R10 flash narrow read high byte");
    drive(0,1,1, 1,0, 0, 0,0, 1, 0, "R10 flash narrow write");
    drive(0,1,1, 1,0, 1, 0,0, 1, 0, "R10 flash wide write no byte addr");
    drive(0,1,1, 1,1, 0, 0,0, 1, 0, "R10 R3 flash narrow output disable");
    drive(0,0,0, 0,1, 1, 0,0, 0, 0, "R5 R12 flash read beside deep pd");
    drive(0,0,1, 0,1, 1, 0,0, 1, 0, "R6 forbidden during read");
    drive(1,1,1, 1,1, 1, 1,1, 0, 0, "R7 flag holds");
    drive(1,0,1, 0,1, 1, 0,0, 0, 0, "R7 flag holds under psram read");
    drive(0,0,1, 1,0, 1, 0,0, 0, 1, "R6 R7 set wins over clear");
    drive(1,1,1, 1,1, 1, 1,1, 0, 1, "R7 clear");
    drive(1,1,1, 1,1, 1, 1,1, 0, 0, "R7 stays clear");
    for (int i = 0; i < 32; i++) begin
      drive(logic'(i[0]), logic'(i[1]), logic'(i[2]), logic'(i[3]), logic'(i[4]),
            logic'(i[1] ^ i[3]), logic'(i[2]), logic'(i[0] ^ i[4]), logic'(i[3]),
            logic'(i[2] & i[4]), "R2 R3 sweep");
    end
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule